// File: doc/BRIEF.md
# Weighted Random Miter Equivalence Tester

This block decides, by Monte Carlo sampling, whether two external combinational circuits with the same inputs compute the same function. After a start request it draws a random bias weight for every input. It then produces a stream of random input vectors in which each bit is 1 with the probability set by its weight. The same vector goes to both circuits. The two returned output words are compared through an XOR miter. The weights are re-drawn after a fixed number of vectors, so one run covers several input distributions.

A run stops on the first vector whose outputs differ. The block then reports a mismatch and keeps the failing vector. If no difference appears before the programmable vector budget is used up, the run ends with the mismatch flag clear. That outcome means the circuits are probably equivalent; it is not a proof.

The circuits under test sit outside the block. A vector is driven from a register, and the circuit outputs are sampled one clock later. The combinational settling therefore never shares a cycle with the vector update.

Top module: `mc_equiv_tester`

## Requirements
- R1: While reset is applied and after it is released, busy, done, mismatch, cut_vec, fail_vector and vectors_applied are all 0.
- R2: A seed of 0 is replaced by 16'hB5C3 to form the effective seed E. Input lane i starts its sample generator at E[7:0] ^ (8'h3B*i mod 256) and its weight generator at E[15:8] ^ (8'h3B*i mod 256). Either start value is replaced by 8'h5A when it would be 0.
- R3: Both 8-bit generators of each lane advance by right-shifting one place and then XORing with 8'hB8 when the bit shifted out was 1.
- R4: Bit i of vector k (counting from 0) is 1 exactly when sample generator i, advanced k times, is unsigned-less than weight generator i, advanced floor(k/REDRAW) times.
- R5: A start in idle is accepted at clock edge e. Vector k appears on cut_vec after edge e+1+2k. The circuit outputs for vector k are sampled at edge e+2+2k, and vectors_applied counts up by one at that edge. busy is 1 from edge e until the run ends.
- R6: If any bit of cut_a_out differs from cut_b_out at a sampling edge, that edge sets mismatch and done, clears busy, and loads that vector into fail_vector. No further vector is driven.
- R7: If the budget is reached without a difference, the run ends with done=1, mismatch=0, busy=0 and vectors_applied equal to the budget.
- R8: A start with a budget of 0 sets done at its edge, with vectors_applied 0 and busy never raised.
- R9: A start request during a run is ignored, together with its seed and budget.
- R10: The results hold while idle until the next accepted start. That start clears done (unless the budget is 0), mismatch, fail_vector and vectors_applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| budget | input | BUDGET_W | Number of vectors before a pass verdict |
| seed | input | 16 | Random seed, 0 selects a built-in value |
| cut_vec | output | N_IN | Vector driven to both circuits |
| cut_a_out | input | N_OUT | Output of the first circuit |
| cut_b_out | input | N_OUT | Output of the second circuit |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has ended |
| mismatch | output | 1 | The last run found a difference |
| fail_vector | output | N_IN | Vector that exposed the difference |
| vectors_applied | output | BUDGET_W | Vectors compared in the current or last run |

## Verification
A wrong generator state shows up on cut_vec within one vector period, two clocks, because every vector bit is visible at the port and is predicted exactly. A drifting weight or a missed re-draw shows up at the first vector after the REDRAW boundary where the sample falls between the right and the wrong weight. A control fault shows up in vectors_applied or done at the very sampling edge where the run should end. The bench therefore models every output on every clock. That model covers runs with equal circuits, a rare difference, a frequent difference and a difference on the first vector.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned SEED_W = 2 * LANE_W;
    localparam logic [LANE_W-1:0] LFSR_MASK = 8'hB8;
    localparam logic [SEED_W-1:0] SEED_FALLBACK = 16'hB5C3;
    localparam logic [LANE_W-1:0] LANE_SPREAD = 8'h3B;
    localparam logic [LANE_W-1:0] LANE_FALLBACK = 8'h5A;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DRIVE  = 2'd1,
        PH_SAMPLE = 2'd2
    } phase_e;

    function automatic logic [LANE_W-1:0] lfsr_next(input logic [LANE_W-1:0] s);
        logic [LANE_W-1:0] r;
        r = s >> 1;
        if (s[0]) r = r ^ LFSR_MASK;
        return r;
    endfunction

    function automatic logic [LANE_W-1:0] lane_start(input logic [LANE_W-1:0] b,
                                                     input int unsigned idx);
        logic [LANE_W-1:0] v;
        v = b ^ (LANE_SPREAD * LANE_W'(idx));
        if (v == '0) v = LANE_FALLBACK;
        return v;
    endfunction
endpackage

// File: rtl/mc_bias_lane.sv
module mc_bias_lane
    import mc_pkg::*;
#(
    parameter int unsigned IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              step_smp_i,
    input  logic              step_wt_i,
    output logic              bit_o
);
    typedef struct packed {
        logic [LANE_W-1:0] smp;
        logic [LANE_W-1:0] wt;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.smp = lane_start(seed_i[LANE_W-1:0], IDX);
            st_d.wt  = lane_start(seed_i[SEED_W-1:LANE_W], IDX);
        end else begin
            if (step_smp_i) st_d.smp = lfsr_next(st_q.smp);
            if (step_wt_i)  st_d.wt  = lfsr_next(st_q.wt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.smp <= LANE_W'(1);
            st_q.wt  <= LANE_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = (st_q.smp < st_q.wt);

    // R3: a generator in use never reaches the all-zero lock-up state
    p_lane_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.smp != '0) && (st_q.wt != '0));

    // R3: a requested sample step always changes the sample state
    p_sample_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_smp_i && !load_i) |=> (st_q.smp != $past(st_q.smp)));

    // R4: the weight only changes on a load or a re-draw
    p_weight_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_wt_i) |=> $stable(st_q.wt));
endmodule

// File: rtl/mc_miter.sv
module mc_miter #(
    parameter int unsigned N_OUT = 2
) (
    input  logic [N_OUT-1:0] a_i,
    input  logic [N_OUT-1:0] b_i,
    output logic             diff_o
);
    logic [N_OUT-1:0] bit_diff;

    for (genvar g = 0; g < N_OUT; g++) begin : g_xor
        assign bit_diff[g] = a_i[g] ^ b_i[g];
    end

    assign diff_o = |bit_diff;
endmodule

// File: rtl/mc_run_ctrl.sv
module mc_run_ctrl
    import mc_pkg::*;
#(
    parameter int unsigned N_IN     = 8,
    parameter int unsigned BUDGET_W = 16,
    parameter int unsigned REDRAW   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [BUDGET_W-1:0] budget_i,
    input  logic [SEED_W-1:0]   seed_i,
    input  logic [N_IN-1:0]     lane_bits_i,
    input  logic                diff_i,
    output logic                load_o,
    output logic [SEED_W-1:0]   eff_seed_o,
    output logic                step_smp_o,
    output logic                step_wt_o,
    output logic [N_IN-1:0]     cut_vec_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                mismatch_o,
    output logic [N_IN-1:0]     fail_o,
    output logic [BUDGET_W-1:0] count_o
);
    localparam int unsigned RC_W = (REDRAW > 1) ? $clog2(REDRAW) : 1;
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(REDRAW - 1);

    typedef struct packed {
        phase_e              ph;
        logic [BUDGET_W-1:0] bud;
        logic [BUDGET_W-1:0] cnt;
        logic [RC_W-1:0]     rc;
        logic [N_IN-1:0]     vec;
        logic [N_IN-1:0]     fail;
        logic                done;
        logic                mis;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic load_d, step_smp_d, step_wt_d;
    logic [BUDGET_W-1:0] cnt_inc;

    assign cnt_inc    = ctl_q.cnt + BUDGET_W'(1);
    assign eff_seed_o = (seed_i == '0) ? SEED_FALLBACK : seed_i;

    always_comb begin
        ctl_d      = ctl_q;
        load_d     = 1'b0;
        step_smp_d = 1'b0;
        step_wt_d  = 1'b0;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    load_d      = 1'b1;
                    ctl_d.bud   = budget_i;
                    ctl_d.cnt   = '0;
                    ctl_d.rc    = '0;
                    ctl_d.mis   = 1'b0;
                    ctl_d.fail  = '0;
                    if (budget_i == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.done = 1'b0;
                        ctl_d.ph   = PH_DRIVE;
                    end
                end
            end
            PH_DRIVE: begin
                ctl_d.vec  = lane_bits_i;
                step_smp_d = 1'b1;
                ctl_d.ph   = PH_SAMPLE;
            end
            PH_SAMPLE: begin
                ctl_d.cnt = cnt_inc;
                if (diff_i) begin
                    ctl_d.mis  = 1'b1;
                    ctl_d.fail = ctl_q.vec;
                    ctl_d.done = 1'b1;
                    ctl_d.ph   = PH_IDLE;
                end else if (cnt_inc == ctl_q.bud) begin
                    ctl_d.done = 1'b1;
                    ctl_d.ph   = PH_IDLE;
                end else begin
                    if (ctl_q.rc == RC_LAST) begin
                        step_wt_d = 1'b1;
                        ctl_d.rc  = '0;
                    end else begin
                        ctl_d.rc = ctl_q.rc + RC_W'(1);
                    end
                    ctl_d.ph = PH_DRIVE;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.ph   <= PH_IDLE;
            ctl_q.bud  <= '0;
            ctl_q.cnt  <= '0;
            ctl_q.rc   <= '0;
            ctl_q.vec  <= '0;
            ctl_q.fail <= '0;
            ctl_q.done <= 1'b0;
            ctl_q.mis  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign load_o     = load_d;
    assign step_smp_o = step_smp_d;
    assign step_wt_o  = step_wt_d;
    assign cut_vec_o  = ctl_q.vec;
    assign busy_o     = (ctl_q.ph != PH_IDLE);
    assign done_o     = ctl_q.done;
    assign mismatch_o = ctl_q.mis;
    assign fail_o     = ctl_q.fail;
    assign count_o    = ctl_q.cnt;

    // R7: a finished run is never still running
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7: the vector count stays below the budget while running
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ctl_q.cnt < ctl_q.bud));

    // R6: a reported mismatch always comes with a finished run
    p_mis_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> done_o);

    // R5: the count grows by at most one per clock during a run
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ((ctl_q.cnt == $past(ctl_q.cnt)) ||
                    (ctl_q.cnt == $past(ctl_q.cnt) + BUDGET_W'(1))));

    // R5: the vector under test is held through its sampling edge
    p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_SAMPLE) |=> $stable(ctl_q.vec));

    // R9: a start request during a run leaves the budget untouched
    p_budget_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ctl_q.bud));

    // R10: results hold while idle without a start
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(ctl_q.fail) && $stable(ctl_q.mis) &&
                                   $stable(ctl_q.cnt) && $stable(ctl_q.done)));
endmodule

// File: rtl/mc_equiv_tester.sv
module mc_equiv_tester
    import mc_pkg::*;
#(
    parameter int unsigned N_IN     = 8,
    parameter int unsigned N_OUT    = 2,
    parameter int unsigned BUDGET_W = 16,
    parameter int unsigned REDRAW   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BUDGET_W-1:0] budget,
    input  logic [SEED_W-1:0]   seed,
    output logic [N_IN-1:0]     cut_vec,
    input  logic [N_OUT-1:0]    cut_a_out,
    input  logic [N_OUT-1:0]    cut_b_out,
    output logic                busy,
    output logic                done,
    output logic                mismatch,
    output logic [N_IN-1:0]     fail_vector,
    output logic [BUDGET_W-1:0] vectors_applied
);
    logic [N_IN-1:0]   lane_bits;
    logic [SEED_W-1:0] eff_seed;
    logic              lane_load, step_smp, step_wt, miter_diff;

    mc_run_ctrl #(
        .N_IN     (N_IN),
        .BUDGET_W (BUDGET_W),
        .REDRAW   (REDRAW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .budget_i    (budget),
        .seed_i      (seed),
        .lane_bits_i (lane_bits),
        .diff_i      (miter_diff),
        .load_o      (lane_load),
        .eff_seed_o  (eff_seed),
        .step_smp_o  (step_smp),
        .step_wt_o   (step_wt),
        .cut_vec_o   (cut_vec),
        .busy_o      (busy),
        .done_o      (done),
        .mismatch_o  (mismatch),
        .fail_o      (fail_vector),
        .count_o     (vectors_applied)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
        mc_bias_lane #(.IDX(g)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (lane_load),
            .seed_i     (eff_seed),
            .step_smp_i (step_smp),
            .step_wt_i  (step_wt),
            .bit_o      (lane_bits[g])
        );
    end

    mc_miter #(.N_OUT(N_OUT)) u_miter (
        .a_i    (cut_a_out),
        .b_i    (cut_b_out),
        .diff_o (miter_diff)
    );
endmodule

// File: tb/mc_equiv_tester_test.sv
module mc_equiv_tester_test;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 8;
    localparam int RD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] budget = '0;
    logic [15:0] seed = '0;
    int          mode = 0;
    logic [7:0]  cut_vec, fail_vector;
    logic [1:0]  a_out, b_out;
    logic        busy, done, mismatch;
    logic [15:0] vectors_applied;

    int errors = 0;
    int checks = 0;
    bit chk_en = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] ref_a(input logic [7:0] x);
        return {(x[0] & x[1]) | (x[2] & x[3]), ^x[7:4]};
    endfunction

    function automatic logic [1:0] ref_b(input logic [7:0] x, input int m);
        logic [1:0] r;
        r = {~(~(x[0] & x[1]) & ~(x[2] & x[3])), x[4] ^ x[5] ^ x[6] ^ x[7]};
        if (m == 1) r[1] = r[1] ^ (&x);
        if (m == 2) r[0] = r[0] ^ (x[0] ^ x[5]);
        if (m == 3) r = ~r;
        return r;
    endfunction

    assign a_out = ref_a(cut_vec);
    assign b_out = ref_b(cut_vec, mode);

    mc_equiv_tester uut (
        .clk(clk), .rst_n(rst_n), .start(start), .budget(budget), .seed(seed),
        .cut_vec(cut_vec), .cut_a_out(a_out), .cut_b_out(b_out),
        .busy(busy), .done(done), .mismatch(mismatch),
        .fail_vector(fail_vector), .vectors_applied(vectors_applied)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference of the requirements
    function automatic int gen_step(input int s);
        int r;
        r = s >> 1;
        if ((s & 1) != 0) r = r ^ 'hB8;
        return r & 'hFF;
    endfunction

    function automatic int gen_start(input int b, input int i);
        int v;
        v = (b ^ ((i * 'h3B) & 'hFF)) & 'hFF;
        return (v == 0) ? 'h5A : v;
    endfunction

    int         m_ph = 0, m_bud = 0, m_cnt = 0, m_rc = 0, m_eff = 0;
    logic [7:0] m_vec = '0, m_fail = '0;
    bit         m_done = 0, m_mis = 0;
    int         m_s[NI];
    int         m_w[NI];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_bud = 0; m_cnt = 0; m_rc = 0;
            m_vec = '0; m_fail = '0; m_done = 0; m_mis = 0;
        end else if (m_ph == 0) begin
            if (start) begin
                m_eff = (seed == 0) ? 'hB5C3 : int'(seed);
                for (int i = 0; i < NI; i++) begin
                    m_s[i] = gen_start(m_eff & 'hFF, i);
                    m_w[i] = gen_start((m_eff >> 8) & 'hFF, i);
                end
                m_bud = int'(budget); m_cnt = 0; m_rc = 0; m_mis = 0; m_fail = '0;
                if (budget == 0) m_done = 1;
                else begin m_done = 0; m_ph = 1; end
            end
        end else if (m_ph == 1) begin
            for (int i = 0; i < NI; i++) begin
                m_vec[i] = (m_s[i] < m_w[i]);
                m_s[i] = gen_step(m_s[i]);
            end
            m_ph = 2;
        end else begin
            m_cnt++;
            if (ref_a(m_vec) != ref_b(m_vec, mode)) begin
                m_mis = 1; m_fail = m_vec; m_done = 1; m_ph = 0;
            end else if (m_cnt == m_bud) begin
                m_done = 1; m_ph = 0;
            end else begin
                m_rc++;
                if (m_rc == RD) begin
                    m_rc = 0;
                    for (int i = 0; i < NI; i++) m_w[i] = gen_step(m_w[i]);
                end
                m_ph = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            chk("R4 vector bits (R2 seeding, R3 stepping)", 32'(cut_vec), 32'(m_vec));
            chk("R5 busy", 32'(busy), 32'(m_ph != 0));
            chk("R5 vectors_applied", 32'(vectors_applied), 32'(m_cnt));
            chk("R7 done", 32'(done), 32'(m_done));
            chk("R6 mismatch", 32'(mismatch), 32'(m_mis));
            chk("R6 fail_vector", 32'(fail_vector), 32'(m_fail));
        end
    end

    logic [7:0] first_vec;
    bit         saw_busy;

    task automatic run(input logic [15:0] sd, input logic [15:0] bg, input int md);
        int guard;
        @(negedge clk); seed = sd; budget = bg; mode = md; start = 1'b1;
        @(negedge clk); start = 1'b0;
        saw_busy = busy;
        if (bg != 0) begin
            @(negedge clk); first_vec = cut_vec;
        end
        guard = 0;
        while (!done && guard < 150000) begin
            @(negedge clk); guard++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  v0;
        logic [15:0] c_hold;
        logic [7:0]  f_hold;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 mismatch", 32'(mismatch), 0);
        chk("R1 cut_vec", 32'(cut_vec), 0);
        chk("R1 fail_vector", 32'(fail_vector), 0);
        chk("R1 vectors_applied", 32'(vectors_applied), 0);
        rst_n = 1'b1;
        chk_en = 1;

        // R7 equal circuits, budget runs out
        run(16'h1234, 16'd12, 0);
        chk("R7 pass count", 32'(vectors_applied), 12);
        chk("R7 pass verdict", 32'(mismatch), 0);

        // R2 zero seed behaves as the fallback seed
        run(16'h0000, 16'd5, 0);
        v0 = first_vec;
        run(16'hB5C3, 16'd5, 0);
        chk("R2 zero seed first vector", 32'(first_vec), 32'(v0));

        // R6 difference on the very first vector
        run(16'h00F1, 16'd50, 3);
        chk("R6 stop after first vector", 32'(vectors_applied), 1);
        chk("R6 fail_vector is first vector", 32'(fail_vector), 32'(first_vec));

        // R10 results hold while idle
        c_hold = vectors_applied; f_hold = fail_vector;
        repeat (6) @(negedge clk);
        chk("R10 count held", 32'(vectors_applied), 32'(c_hold));
        chk("R10 fail held", 32'(fail_vector), 32'(f_hold));
        chk("R10 mismatch held", 32'(mismatch), 1);

        // R10 next start clears results
        @(negedge clk); seed = 16'h4D2E; budget = 16'd4; mode = 0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R10 cleared mismatch", 32'(mismatch), 0);
        chk("R10 cleared fail_vector", 32'(fail_vector), 0);
        chk("R10 cleared done", 32'(done), 0);
        while (!done) @(negedge clk);

        // R6 frequent and rare differences, long runs cross REDRAW (R4)
        for (int s = 1; s <= 4; s++) begin
            run(16'(s * 16'h1357), 16'd200, 2);
            if (mismatch)
                chk("R6 fail_vector differs", 32'(ref_a(fail_vector) != ref_b(fail_vector, 2)), 1);
        end
        run(16'hA5A5, 16'd300, 1);
        run(16'h7E01, 16'd100, 0);
        chk("R4 long pass count", 32'(vectors_applied), 100);

        // R8 zero budget
        run(16'h2222, 16'd0, 0);
        chk("R8 done", 32'(done), 1);
        chk("R8 never busy", 32'(saw_busy), 0);
        chk("R8 count", 32'(vectors_applied), 0);

        // R9 start during a run is ignored
        @(negedge clk); seed = 16'h0BAD; budget = 16'd40; mode = 0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (9) @(negedge clk);
        seed = 16'h1111; budget = 16'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        chk("R9 budget kept", 32'(vectors_applied), 40);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule